// File: doc/BRIEF.md
# Edge-Latched Secondary Interrupt Collector

This block gathers a set of edge-type event sources into a single interrupt line for a parent interrupt controller. It registers a copy of every source input. A rising transition on a source sets a sticky pending bit for that source. The pending bits are kept in a pending register. An enable register chooses which pending bits may drive the output line. The output is high while any pending bit is also enabled.

Software reaches the two registers over a simple synchronous register bus. The bus has a write strobe, a byte address and write data, and the read data is a combinational function of the address. Pending bits latch whether or not their source is enabled. Software should therefore clear stale events before it enables a source. Clearing uses write-zero semantics: a 0 written to a pending bit clears it, and a 1 written to it leaves it as it was. The number of sources is a parameter, with a default of 32.

Top module: `evt_bridge_intc`

## Requirements
- R1: After a synchronous active-low reset, the pending register and the enable register both read 0 and `irq_out` is low.
- R2: A 0-to-1 transition of `src_in[i]`, seen against the registered copy of that input, sets pending bit i at the next rising clock edge. A source that stays high, or that falls, sets nothing.
- R3: A pending bit sets on an edge even while enable bit i is 0.
- R4: A write to byte offset 0x00 clears each pending bit whose write-data bit is 0. It leaves unchanged each pending bit whose write-data bit is 1. A write never sets a pending bit.
- R5: Writing 0x00000000 to offset 0x00 clears every pending bit.
- R6: If a new edge on source i and a write of 0 to pending bit i occur in the same cycle, the bit is 1 afterwards.
- R7: A write to byte offset 0x04 loads the enable register from the write data. Reading offset 0x04 returns it. Bit positions at or above the source count read 0.
- R8: `irq_out` is 1 exactly when some bit i has both pending bit i and enable bit i set. An enable bit of 0 removes that source's contribution.
- R9: Reading offset 0x00 returns the pending bits. Reading any other offset returns 0. A write to any other offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Event sources, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt line to the parent controller |

## Verification
The assertions assume that `src_in` is already synchronous to `clk`. They also assume that `bus_we`, `bus_addr` and `bus_wdata` are stable around each rising edge, because edge detection and register writes both sample at that edge. The stimulus meets these assumptions by changing every input only on the falling clock edge. It uses no sub-cycle glitches, so each level the design samples is the level the reference model sees. Directed phases hold sources high across clears, collide edges with clearing writes, and write to unused offsets. A long phase with random sources and random bus traffic then exercises the same rules together.

// File: rtl/evt_intc_pkg.sv
// Shared constants for the edge-latched interrupt collector.
// Assumes byte addressing with 32-bit registers.
package evt_intc_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_NUM_SRC = 32;
    localparam logic [7:0] OFS_PENDING = 8'h00;
    localparam logic [7:0] OFS_ENABLE  = 8'h04;
endpackage

// File: rtl/evt_edge_detect.sv
// Rising-edge detector: keeps one registered copy per source and flags a
// 0-to-1 transition for one cycle. Assumes src is synchronous to clk.
module evt_edge_detect #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    output logic [NUM_SRC-1:0] rise
);
    logic [NUM_SRC-1:0] prev_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        // Purpose: remember the level of source g from the previous cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= src[g];
        end

        assign rise[g] = src[g] & ~prev_q[g];

        // R2: a flagged edge never repeats on the next cycle
        p_rise_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/evt_cause_latch.sv
// Sticky pending register. Edges set bits; a clearing write zeroes the bits
// whose data bit is 0. An edge wins over a clear on the same bit.
module evt_cause_latch #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] pend_q
);
    logic [NUM_SRC-1:0] keep;

    // Purpose: select which held bits survive this cycle.
    always_comb begin
        keep = clr_we ? clr_data : {NUM_SRC{1'b1}};
    end

    // Purpose: update pending bits, with new edges OR-ed in last.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & keep) | rise;
    end

    // R2: without a write, an edge sets its bit
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((pend_q & $past(rise)) == $past(rise)));
    // R4: bits are sticky while no write occurs
    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
    // R4: zero data bits clear unless an edge arrives
    p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & ~$past(clr_data) & ~$past(rise)) == '0));
    // R6: an edge colliding with a clear still sets the bit
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/evt_mask_reg.sv
// Enable register: loaded whole on a write, reset to all-disabled.
module evt_mask_reg #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] en_q
);
    // Purpose: hold the per-source enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (we) en_q <= wdata;
    end

    // R7: a write lands in the register on the next cycle
    p_enable_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en_q == $past(wdata)));
    // R7: without a write the register holds
    p_enable_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en_q));
endmodule

// File: rtl/evt_bridge_intc.sv
// Top of the edge-latched interrupt collector: decodes the register bus,
// joins edge detection, pending and enable state, and drives one line.
// Assumes synchronous sources and NUM_SRC <= DATA_W.
module evt_bridge_intc
    import evt_intc_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);

    logic [NUM_SRC-1:0] rise, pend_q, en_q;
    logic hit_pend, hit_en;

    assign hit_pend = (bus_addr == A_PEND);
    assign hit_en   = (bus_addr == A_EN);

    evt_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .src(src_in), .rise(rise));

    evt_cause_latch #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .rise(rise),
        .clr_we(bus_we & hit_pend), .clr_data(bus_wdata[NUM_SRC-1:0]),
        .pend_q(pend_q));

    evt_mask_reg #(.NUM_SRC(NUM_SRC)) u_en (
        .clk(clk), .rst_n(rst_n), .we(bus_we & hit_en),
        .wdata(bus_wdata[NUM_SRC-1:0]), .en_q(en_q));

    // Purpose: return the addressed register, zero-extended.
    always_comb begin
        bus_rdata = '0;
        if (hit_pend)    bus_rdata[NUM_SRC-1:0] = pend_q;
        else if (hit_en) bus_rdata[NUM_SRC-1:0] = en_q;
    end

    assign irq_out = |(pend_q & en_q);

    // R1: reset leaves both registers clear
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0));
    // R8: a fully disabled collector stays quiet
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out);
    // R9: writes elsewhere leave the enable register alone
    p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit_pend && !hit_en) |=> (en_q == $past(en_q)));
endmodule

// File: tb/evt_bridge_intc_test.sv
`timescale 1ns/1ps
module evt_bridge_intc_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    // behavioural reference state
    bit m_pend [N];
    bit m_en   [N];
    bit m_prev [N];

    always #2.5 clk = ~clk;

    evt_bridge_intc uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out));

    // reference model: one update per rising edge
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_pend[i] = 0; m_en[i] = 0; m_prev[i] = 0;
            end else begin
                bit edge_seen;
                edge_seen = src_in[i] && !m_prev[i];
                if (bus_we && bus_addr == 8'h00 && !bus_wdata[i]) m_pend[i] = 0;
                if (edge_seen) m_pend[i] = 1;
                if (bus_we && bus_addr == 8'h04) m_en[i] = bus_wdata[i];
                m_prev[i] = src_in[i];
            end
        end
    end

    task automatic compare();
        logic [31:0] exp_rd;
        bit exp_irq;
        exp_rd = '0;
        exp_irq = 0;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && m_en[i]) exp_irq = 1;
            if (bus_addr == 8'h00) exp_rd[i] = m_pend[i];
            else if (bus_addr == 8'h04) exp_rd[i] = m_en[i];
        end
        n_cmp++;
        if (bus_rdata !== exp_rd || irq_out !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, bus_rdata, irq_out, exp_rd, exp_irq);
        end
    endtask

    // one cycle: check the settled state, then drive new inputs
    task automatic cyc(input logic [N-1:0] s, input logic we,
                       input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        compare();
        src_in = s; bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [N-1:0] s, input logic [7:0] a);
        cyc(s, 1'b0, a, 32'h0);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) rd('0, 8'h00);
        rd('0, 8'h04);
        rst_n = 1'b1;
        rd('0, 8'h00); rd('0, 8'h04);

        // R7: enable register load and readback
        tag = "R7";
        cyc('0, 1'b1, 8'h04, 32'hFFFF_0000);
        rd('0, 8'h04); rd('0, 8'h04);

        // R3: edge on disabled source 3 latches, line stays low
        tag = "R3";
        rd(32'h8, 8'h00); rd(32'h0, 8'h00); rd(32'h0, 8'h00);

        // R8: enabling source 3 raises the line
        tag = "R8";
        cyc('0, 1'b1, 8'h04, 32'h0000_0008);
        rd('0, 8'h00); rd('0, 8'h04);

        // R4: write ones keeps, write zero on bit 3 clears only it
        tag = "R4";
        rd(32'h30, 8'h00);
        cyc('0, 1'b1, 8'h00, 32'hFFFF_FFFF);
        rd('0, 8'h00);
        cyc('0, 1'b1, 8'h00, 32'hFFFF_FFF7);
        rd('0, 8'h00); rd('0, 8'h00);

        // R2: held-high source sets once, not again after clear
        tag = "R2";
        rd(32'h100, 8'h00);
        cyc(32'h100, 1'b1, 8'h00, 32'h0);
        rd(32'h100, 8'h00); rd(32'h100, 8'h00);
        rd(32'h0, 8'h00); rd(32'h0, 8'h00);

        // R6: edge and clearing write on bit 9 in the same cycle
        tag = "R6";
        cyc(32'h200, 1'b1, 8'h00, 32'h0);
        rd(32'h200, 8'h00); rd('0, 8'h00);

        // R5: many pending bits cleared by one all-zero write
        tag = "R5";
        rd(32'hA5A5_5A5A, 8'h00);
        rd('0, 8'h00);
        cyc('0, 1'b1, 8'h00, 32'h0);
        rd('0, 8'h00); rd('0, 8'h00);

        // R9: unused offsets read 0 and ignore writes
        tag = "R9";
        cyc('0, 1'b1, 8'h04, 32'h0F0F_0F0F);
        rd(32'h0101_0101, 8'h08);
        cyc('0, 1'b1, 8'h08, 32'h0);
        cyc('0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
        rd('0, 8'h00); rd('0, 8'h04); rd('0, 8'h10);

        // random mix of all rules
        tag = "R8";
        for (int k = 0; k < 600; k++) begin
            logic [7:0] a;
            int pick;
            pick = int'($urandom_range(0, 5));
            a = (pick < 3) ? 8'h00 : (pick < 5) ? 8'h04 : 8'h08;
            cyc($urandom & $urandom, ($urandom_range(0, 3) == 0), a,
                ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom);
        end
        rd('0, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule